// File: doc/BRIEF.md
# Segmented Thermometer Steering Decoder

This block is the digital front end of a current-steering converter whose analog array is split into two unary groups. An 8-bit code is registered on a rising clock edge. On the following edge the stored code becomes two registered switch-control vectors. The upper five code bits select how many of 31 equal coarse segments are steered to output node A. The lower three bits select how many of 7 equal fine units, each worth one eighth of a segment, are steered there. Every element not steered to A goes to B.

A control bit of 1 sends its element to A and a 0 sends it to B. Each element therefore always feeds exactly one node. Both vectors fill from bit 0 upward, so a one-step change of code moves only the elements at the boundary. Two weighted-sum outputs count the active weight on each node in fine-unit steps, so the steering can be checked against the code without any analog model. A sleep input freezes both pipeline stages, and a synchronous reset clears them to code 0.

Top module: `seg_dac_steer`

## Requirements
- R1: A code present on `code_in` at a rising edge with `sleep` low is reflected on every output after the second rising edge, provided `sleep` is also low at that second edge.
- R2: For a decoded code c, `seg_sel_a[i]` is 1 exactly when i < c[7:3], for i = 0..30. A 1 steers the segment to A and a 0 steers it to B.
- R3: For a decoded code c, `unit_sel_a[j]` is 1 exactly when j < c[2:0], for j = 0..6, with the same steering meaning as R2.
- R4: `weight_a` equals 8 × (segments steered to A) + (units steered to A), and so equals the decoded code c.
- R5: `weight_b` equals 8 × (segments steered to B) + (units steered to B), which is 255 − c. `weight_a + weight_b` is always 255.
- R6: Code 0 gives all-zero vectors, `weight_a` = 0 and `weight_b` = 255. Code 255 gives all-one vectors, `weight_a` = 255 and `weight_b` = 0.
- R7: While `sleep` is high, neither stage updates. All outputs hold their values, and `code_in` is ignored. After release, the code that was captured before sleep is decoded first.
- R8: When `rst` is high at a rising edge, both stages clear: vectors become all zero, `weight_a` becomes 0 and `weight_b` becomes 255 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Freezes both stages while high |
| code_in | input | 8 | Input code, unsigned |
| seg_sel_a | output | 31 | Coarse segment steering, 1 = node A |
| unit_sel_a | output | 7 | Fine unit steering, 1 = node A |
| weight_a | output | 9 | Weight steered to A in fine units |
| weight_b | output | 9 | Weight steered to B in fine units |

## Verification
Every output is due after the second rising edge that follows the edge which accepted a code, because one register captures the code and a second holds the decoded vectors. Reset takes effect on the first edge. The driver keeps a two-stage model that advances only on edges where `sleep` is low and clears on reset edges. At each edge it queues the value the outputs must show after that edge. The monitor samples mid-cycle, after the same edge, so each queued value is compared in exactly the cycle it is due. This covers the cycles when sleep is entered and released.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
    localparam int CODE_W_DEF = 8;
    localparam int LSB_W_DEF  = 3;

    function automatic int unary_len(input int bits);
        return (1 << bits) - 1;
    endfunction
endpackage

// File: rtl/therm_dec.sv
module therm_dec #(
    parameter int IN_W  = 3,
    parameter int OUT_N = (1 << IN_W) - 1
) (
    input  logic [IN_W-1:0]  bin_i,
    output logic [OUT_N-1:0] therm_o
);
    for (genvar i = 0; i < OUT_N; i++) begin : g_lvl
        assign therm_o[i] = (int'(bin_i) > i);
    end
endmodule

// File: rtl/ones_count.sv
module ones_count #(
    parameter int N = 7,
    parameter int W = $clog2(N + 1)
) (
    input  logic [N-1:0] vec_i,
    output logic [W-1:0] cnt_o
);
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < N; i++) begin
            cnt_o = cnt_o + W'(vec_i[i]);
        end
    end
endmodule

// File: rtl/seg_dac_steer.sv
module seg_dac_steer
    import seg_dac_pkg::*;
#(
    parameter int CODE_W = CODE_W_DEF,
    parameter int LSB_W  = LSB_W_DEF,
    localparam int MSB_W  = CODE_W - LSB_W,
    localparam int SEG_N  = (1 << MSB_W) - 1,
    localparam int UNIT_N = (1 << LSB_W) - 1,
    localparam int SUM_W  = CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep,
    input  logic [CODE_W-1:0] code_in,
    output logic [SEG_N-1:0]  seg_sel_a,
    output logic [UNIT_N-1:0] unit_sel_a,
    output logic [SUM_W-1:0]  weight_a,
    output logic [SUM_W-1:0]  weight_b
);
    localparam int SEG_CW  = $clog2(SEG_N + 1);
    localparam int UNIT_CW = $clog2(UNIT_N + 1);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [SEG_N-1:0]  seg;
        logic [UNIT_N-1:0] unit;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [SEG_N-1:0]  seg_therm;
    logic [UNIT_N-1:0] unit_therm;

    therm_dec #(.IN_W(MSB_W), .OUT_N(SEG_N)) u_seg_dec (
        .bin_i   (pipe_q.code[CODE_W-1:LSB_W]),
        .therm_o (seg_therm)
    );

    therm_dec #(.IN_W(LSB_W), .OUT_N(UNIT_N)) u_unit_dec (
        .bin_i   (pipe_q.code[LSB_W-1:0]),
        .therm_o (unit_therm)
    );

    always_comb begin
        pipe_d = pipe_q;
        if (!sleep) begin
            pipe_d.code = code_in;
            pipe_d.seg  = seg_therm;
            pipe_d.unit = unit_therm;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    logic [SEG_CW-1:0]  seg_on, seg_off;
    logic [UNIT_CW-1:0] unit_on, unit_off;

    ones_count #(.N(SEG_N), .W(SEG_CW)) u_cnt_seg_a (
        .vec_i (pipe_q.seg), .cnt_o (seg_on)
    );
    ones_count #(.N(SEG_N), .W(SEG_CW)) u_cnt_seg_b (
        .vec_i (~pipe_q.seg), .cnt_o (seg_off)
    );
    ones_count #(.N(UNIT_N), .W(UNIT_CW)) u_cnt_unit_a (
        .vec_i (pipe_q.unit), .cnt_o (unit_on)
    );
    ones_count #(.N(UNIT_N), .W(UNIT_CW)) u_cnt_unit_b (
        .vec_i (~pipe_q.unit), .cnt_o (unit_off)
    );

    assign seg_sel_a  = pipe_q.seg;
    assign unit_sel_a = pipe_q.unit;
    assign weight_a   = SUM_W'({seg_on, {LSB_W{1'b0}}})  + SUM_W'(unit_on);
    assign weight_b   = SUM_W'({seg_off, {LSB_W{1'b0}}}) + SUM_W'(unit_off);
endmodule

// File: rtl/seg_dac_steer_chk.sv
module seg_dac_steer_chk #(
    parameter int CODE_W = 8,
    parameter int LSB_W  = 3,
    localparam int MSB_W  = CODE_W - LSB_W,
    localparam int SEG_N  = (1 << MSB_W) - 1,
    localparam int UNIT_N = (1 << LSB_W) - 1,
    localparam int SUM_W  = CODE_W + 1,
    localparam int FULL   = (1 << CODE_W) - 1
) (
    input logic              clk,
    input logic              rst,
    input logic              sleep,
    input logic [CODE_W-1:0] code_in,
    input logic [SEG_N-1:0]  seg_sel_a,
    input logic [UNIT_N-1:0] unit_sel_a,
    input logic [SUM_W-1:0]  weight_a,
    input logic [SUM_W-1:0]  weight_b
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst) age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    a_r1_two_edge_latency: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && !$past(sleep) && !$past(sleep, 2))
            |-> weight_a == SUM_W'($past(code_in, 2)));

    a_r2_seg_thermometer: assert property (@(posedge clk) disable iff (rst)
        (seg_sel_a & SEG_N'(seg_sel_a + 1'b1)) == '0);

    a_r3_unit_thermometer: assert property (@(posedge clk) disable iff (rst)
        (unit_sel_a & UNIT_N'(unit_sel_a + 1'b1)) == '0);

    a_r5_total_weight: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0) |-> (weight_a + weight_b) == SUM_W'(FULL));

    a_r7_sleep_hold: assert property (@(posedge clk) disable iff (rst)
        (age != 2'd0 && $past(sleep))
            |-> ($stable(seg_sel_a) && $stable(unit_sel_a) && $stable(weight_a)));

    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (seg_sel_a == '0 && unit_sel_a == '0 && weight_b == SUM_W'(FULL)));
endmodule

bind seg_dac_steer seg_dac_steer_chk #(.CODE_W(CODE_W), .LSB_W(LSB_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sleep      (sleep),
    .code_in    (code_in),
    .seg_sel_a  (seg_sel_a),
    .unit_sel_a (unit_sel_a),
    .weight_a   (weight_a),
    .weight_b   (weight_b)
);

// File: tb/tb_seg_dac_steer.sv
`timescale 1ns/1ps
module tb_seg_dac_steer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sleep = 1'b0;
    logic [7:0]  code_in = '0;
    logic [30:0] seg_sel_a;
    logic [6:0]  unit_sel_a;
    logic [8:0]  weight_a, weight_b;

    always #4 clk = ~clk;

    seg_dac_steer dut (
        .clk(clk), .rst(rst), .sleep(sleep), .code_in(code_in),
        .seg_sel_a(seg_sel_a), .unit_sel_a(unit_sel_a),
        .weight_a(weight_a), .weight_b(weight_b)
    );

    typedef struct {
        int    code;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    int m_cap = 0;
    int m_out = 0;
    bit done = 0;

    task automatic step(input int c, input bit sl, input bit r, input string tag);
        exp_t e;
        @(negedge clk);
        code_in = 8'(c);
        sleep   = sl;
        rst     = r;
        @(posedge clk);
        #1;
        if (r) begin
            m_cap = 0;
            m_out = 0;
        end else if (!sl) begin
            m_out = m_cap;
            m_cap = c;
        end
        e.code = m_out;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic chk(input bit ok, input string req, input string ctx,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s (%s) actual=%0h expected=%0h", req, ctx, act, exp);
        end
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #3;
            if (exp_q.size() != 0) begin
                exp_t e;
                logic [30:0] es;
                logic [6:0]  eu;
                e  = exp_q.pop_front();
                es = 31'((64'd1 << (e.code >> 3)) - 1);
                eu = 7'((16'd1 << (e.code & 7)) - 1);
                chk(seg_sel_a == es, "R2", e.tag, seg_sel_a, es);
                chk(unit_sel_a == eu, "R3", e.tag, unit_sel_a, eu);
                chk(int'(weight_a) == e.code, "R4", e.tag, weight_a, e.code);
                chk(int'(weight_b) == 255 - e.code, "R5", e.tag, weight_b, 255 - e.code);
            end
        end
    end

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        logic [7:0] lfsr = 8'hA5;
        // R8: reset state
        for (int i = 0; i < 3; i++) step(0, 0, 1, "R8");
        // R1: full sweep, each result due two edges later
        for (int c = 0; c < 256; c++) step(c, 0, 0, "R1");
        // R6: endpoints back to back
        step(255, 0, 0, "R6");
        step(0, 0, 0, "R6");
        step(255, 0, 0, "R6");
        step(0, 0, 0, "R6");
        step(255, 0, 0, "R6");
        // pseudo-random codes
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(int'(lfsr), 0, 0, "R1");
        end
        // R7: sleep holds, codes ignored, then release
        step(37, 0, 0, "R1");
        step(200, 0, 0, "R1");
        for (int i = 0; i < 6; i++) step(i * 41 + 3, 1, 0, "R7");
        step(90, 0, 0, "R7");
        step(91, 0, 0, "R7");
        step(92, 0, 0, "R7");
        // sleep for one edge only
        step(10, 1, 0, "R7");
        step(11, 0, 0, "R7");
        step(12, 0, 0, "R7");
        // R8: reset mid-stream, including while asleep
        step(250, 0, 0, "R1");
        step(251, 1, 1, "R8");
        step(7, 0, 0, "R8");
        step(8, 0, 0, "R8");
        step(8, 0, 0, "R8");
        @(posedge clk);
        #5;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule